// File: doc/BRIEF.md
# UART Interrupt Mask and Sticky Event Status

This block collects thirteen single-cycle event pulses from a serial port (receive and transmit FIFO levels, line errors, timeout, modem line change, transmit overflow) and keeps one sticky status bit for each. A mask selects which latched events may raise the single level interrupt line. The interrupt is high while any status bit that is set also has its mask bit set.

Software changes the mask through two write-only registers. Writing ones to the set register turns mask bits on. Writing ones to the clear register turns them off. In both registers, zero bits leave the mask alone. The mask can be read back at its own offset. The status register is read at its offset and cleared one bit at a time by writing ones. The register port has one write strobe, an address, write data and a combinational read-data output.

Top module: `uart_evt_irq`

## Requirements
- R1: After synchronous reset the mask and the status are all zeros, the interrupt is low, and both readable offsets return zero.
- R2: A write to offset 0x08 sets every mask bit whose write-data bit is one. Mask bits whose write-data bit is zero keep their value.
- R3: A write to offset 0x0C clears every mask bit whose write-data bit is one. Other mask bits keep their value.
- R4: An event pulse on input bit i sets status bit i on the next clock edge, whatever the mask holds. The bit then stays set until software clears it.
- R5: A write to offset 0x14 clears each status bit whose write-data bit is one and leaves the other status bits unchanged.
- R6: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: The interrupt output is high exactly when at least one bit is set in both the status and the mask. It follows a register change without extra delay.
- R8: A read of offset 0x10 returns the mask in bits 12:0. A read of offset 0x14 returns the status in bits 12:0. Any other offset returns zero, and bits above 12 always read zero.
- R9: Writes to offset 0x10, to unused offsets, and to write-data bits above 12 change neither the mask nor the status.
- R10: Status bit positions are fixed as follows: 0 receive trigger, 1 receive empty, 2 receive full, 3 transmit empty, 4 transmit full, 5 receive overflow, 6 framing error, 7 parity error, 8 receive timeout, 9 modem status change, 10 transmit trigger, 11 transmit nearly full, 12 transmit overflow. Event input bit i maps to status bit i and to no other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 13 | Per-source event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset for read and write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
The case that is hardest to reach from the ports is a status clear that lands in the same cycle as a new event on the same bit. It only shows up when the write strobe and the event pulse line up on one clock edge. The bench therefore drives both from a single task call. In that call, one bit is both pulsed and cleared and a neighbouring bit is only cleared, so the set-wins rule and the plain clear are checked in one read. A walk over all thirteen sources, with the status cleared between steps, confirms that each event lands on its own bit only.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 13;
    localparam int OFS_W   = 8;

    // Byte offsets decoded by the register port
    localparam logic [OFS_W-1:0] OFS_EN_SET  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_EN_CLR  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_MASK_RD = 8'h10;
    localparam logic [OFS_W-1:0] OFS_STAT    = 8'h14;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    // Event source positions in the status and mask vectors
    typedef enum int unsigned {
        SRC_RX_TRIG     = 0,
        SRC_RX_EMPTY    = 1,
        SRC_RX_FULL     = 2,
        SRC_TX_EMPTY    = 3,
        SRC_TX_FULL     = 4,
        SRC_RX_OVF      = 5,
        SRC_FRAME_ERR   = 6,
        SRC_PARITY_ERR  = 7,
        SRC_RX_TIMEOUT  = 8,
        SRC_MODEM_CHG   = 9,
        SRC_TX_TRIG     = 10,
        SRC_TX_NEARFULL = 11,
        SRC_TX_OVF      = 12
    } src_id_e;

    // Decoded write request
    typedef struct packed {
        logic     set_mask;
        logic     clr_mask;
        logic     clr_stat;
        src_vec_t bits;
    } reg_wr_t;

    // Mask update: a bit both set and cleared keeps its value
    function automatic src_vec_t mask_next(input src_vec_t cur,
                                           input src_vec_t set_v,
                                           input src_vec_t clr_v);
        src_vec_t r;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (set_v[i] && !clr_v[i])
                r[i] = 1'b1;
            else if (clr_v[i] && !set_v[i])
                r[i] = 1'b0;
            else
                r[i] = cur[i];
        end
        return r;
    endfunction

    // Status update: an event has priority over a clear
    function automatic logic stat_bit_next(input logic cur,
                                           input logic ev,
                                           input logic clr);
        return ev | (cur & ~clr);
    endfunction

endpackage

// File: rtl/uart_irq_decode.sv
module uart_irq_decode
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_wr_t           cmd
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STAT);

    always_comb begin
        cmd          = '0;
        cmd.bits     = wdata[NUM_SRC-1:0];
        cmd.set_mask = wr && (addr == A_SET);
        cmd.clr_mask = wr && (addr == A_CLR);
        cmd.clr_stat = wr && (addr == A_ST);
    end
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  cmd,
    output src_vec_t mask_q
);
    src_vec_t set_v;
    src_vec_t clr_v;

    assign set_v = cmd.set_mask ? cmd.bits : '0;
    assign clr_v = cmd.clr_mask ? cmd.bits : '0;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= mask_next(mask_q, set_v, clr_v);
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  reg_wr_t  cmd,
    output src_vec_t stat_q
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic clr_b;
        assign clr_b = cmd.clr_stat & cmd.bits[g];
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[g] <= 1'b0;
            else
                stat_q[g] <= stat_bit_next(stat_q[g], evt[g], clr_b);
        end
    end
endmodule

// File: rtl/uart_irq_readmux.sv
module uart_irq_readmux
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          mask_q,
    input  src_vec_t          stat_q,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK_RD);
    localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(OFS_STAT);

    always_comb begin
        rdata = '0;
        if (addr == A_MASK)
            rdata = DATA_W'(mask_q);
        else if (addr == A_ST)
            rdata = DATA_W'(stat_q);
    end
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [12:0]       evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    reg_wr_t  cmd;
    src_vec_t mask_q;
    src_vec_t stat_q;

    uart_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    uart_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mask_q (mask_q)
    );

    uart_irq_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .cmd    (cmd),
        .stat_q (stat_q)
    );

    uart_irq_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .addr   (bus_addr),
        .mask_q (mask_q),
        .stat_q (stat_q),
        .rdata  (bus_rdata)
    );

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/uart_evt_irq_chk.sv
module uart_evt_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [12:0]       evt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              irq,
    input src_vec_t          mask_q,
    input src_vec_t          stat_q
);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STAT);

    src_vec_t wbits;
    assign wbits = bus_wdata[NUM_SRC-1:0];

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && stat_q == '0));

    p_set_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SET) |=> ((mask_q & $past(wbits)) == $past(wbits)));

    p_clr_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CLR) |=> ((mask_q & $past(wbits)) == '0));

    p_evt_latch_r4: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_ST) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ST && evt == '0) |=> ((stat_q & $past(wbits)) == '0));

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_ST && (evt & wbits) != '0)
        |=> ((stat_q & $past(evt & wbits)) == $past(evt & wbits)));

    p_irq_needs_both_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0 && mask_q != '0));

    p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(mask_q));
endmodule

bind uart_evt_irq uart_evt_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .mask_q    (mask_q),
    .stat_q    (stat_q)
);

// File: tb/uart_evt_irq_tb.sv
`timescale 1ns/1ps
module uart_evt_irq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] evt = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #4 clk = ~clk;

    uart_evt_irq u_dut (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Reference state built from the requirements
    logic [12:0] m_mask = '0;
    logic [12:0] m_stat = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    bit chk_valid = 0;

    logic [31:0] q_data[$];
    logic        q_irq[$];
    string       q_tag[$];

    // Monitor: pops an expected item on each flagged cycle
    always @(negedge clk) begin
        if (chk_valid && q_data.size() > 0) begin
            logic [31:0] ed;
            logic        ei;
            string       t;
            ed = q_data.pop_front();
            ei = q_irq.pop_front();
            t  = q_tag.pop_front();
            n_chk++;
            if (bus_rdata !== ed || irq !== ei) begin
                n_fail++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         t, bus_rdata, irq, ed, ei);
            end
        end
    end

    // One bus/event cycle; model updated from R2..R6, R9
    task automatic cyc(input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic [12:0] e);
        @(posedge clk); #1;
        bus_wr = w; bus_addr = a; bus_wdata = d; evt = e;
        if (w && a == 8'h08) m_mask = m_mask | d[12:0];
        if (w && a == 8'h0C) m_mask = m_mask & ~d[12:0];
        if (w && a == 8'h14) m_stat = m_stat & ~d[12:0];
        m_stat = m_stat | e;
        @(posedge clk); #1;
        bus_wr = 1'b0; evt = '0;
    endtask

    // Driver side of the scoreboard: read offset a and expect R7/R8 values
    task automatic chk(input logic [7:0] a, input string tag);
        logic [31:0] ed;
        ed = (a == 8'h10) ? {19'b0, m_mask} :
             (a == 8'h14) ? {19'b0, m_stat} : 32'h0;
        bus_addr = a;
        q_data.push_back(ed);
        q_irq.push_back(|(m_mask & m_stat));
        q_tag.push_back(tag);
        chk_valid = 1'b1;
        @(negedge clk); #1;
        chk_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; bus_wr = 1'b0; evt = '0;
        m_mask = '0; m_stat = '0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state, R8 unused offset reads zero
        chk(8'h10, "R1 mask after reset");
        chk(8'h14, "R1 status after reset");
        chk(8'h08, "R8 write-only offset reads zero");

        // R4 event latches while masked, R10 position
        cyc(1'b0, 8'h00, 32'h0, 13'h0008);
        chk(8'h14, "R4 masked event latches (R10 tx empty bit 3)");
        cyc(1'b0, 8'h00, 32'h0, 13'h0000);
        chk(8'h14, "R4 status sticky without clear");

        // R2 set mask, R7 interrupt
        cyc(1'b1, 8'h08, 32'h0000_0008, 13'h0);
        chk(8'h10, "R2 enable sets bit, R7 irq high");
        cyc(1'b1, 8'h08, 32'h0000_0011, 13'h0);
        chk(8'h10, "R2 zeros leave mask bits unchanged");

        // R3 clear mask, R7 interrupt drops
        cyc(1'b1, 8'h0C, 32'h0000_0008, 13'h0);
        chk(8'h10, "R3 disable clears bit, R7 irq low");
        chk(8'h14, "R7 status kept while irq low");

        // R9 writes that must not touch the mask or status
        cyc(1'b1, 8'h10, 32'hFFFF_FFFF, 13'h0);
        chk(8'h10, "R9 write to mask view ignored");
        cyc(1'b1, 8'h04, 32'hFFFF_FFFF, 13'h0);
        chk(8'h10, "R9 unused offset write, mask");
        chk(8'h14, "R9 unused offset write, status");
        cyc(1'b1, 8'h08, 32'hFFFF_E000, 13'h0);
        chk(8'h10, "R9 upper data bits ignored, R8 upper read zero");

        // R4 all sources, R5 partial clear
        cyc(1'b0, 8'h00, 32'h0, 13'h1FFF);
        chk(8'h14, "R4 all sources latched");
        cyc(1'b1, 8'h14, 32'h0000_0F0F, 13'h0);
        chk(8'h14, "R5 write-one-to-clear partial");

        // R6 set wins over clear on bit 4; bit 5 only cleared
        cyc(1'b1, 8'h14, 32'h0000_0030, 13'h0010);
        chk(8'h14, "R6 event beats clear, neighbour cleared");
        chk(8'h10, "R7 irq with mask and status overlap");

        // R10 walk: each event input reaches its own status bit only
        for (int i = 0; i < 13; i++) begin
            cyc(1'b1, 8'h14, 32'h0000_1FFF, 13'h0);
            cyc(1'b0, 8'h00, 32'h0, 13'(1) << i);
            chk(8'h14, $sformatf("R10 source %0d maps to its own bit", i));
        end

        // R1 reset in mid-run clears everything
        cyc(1'b1, 8'h08, 32'h0000_1FFF, 13'h1FFF);
        chk(8'h14, "R7 full mask and status");
        do_reset();
        chk(8'h10, "R1 mask after mid-run reset");
        chk(8'h14, "R1 status after mid-run reset");

        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            finish_run();
        end
    end
endmodule